// File: doc/BRIEF.md
# Configuration Status Interrupt Monitor

This block samples twelve asynchronous configuration status signals coming from a programmable fabric, brings them into the local clock domain, and turns them into one interrupt line. Each signal can raise an interrupt. That interrupt is either level-sensitive or edge-latched, is active high or active low, and is gated by separate enable and mask controls. Software reads the synchronized input levels directly. It clears edge-latched events by writing ones to a clear register.

The signals occupy fixed positions on the 12-bit input:

| Bit | Signal |
|-----|--------|
| 0 | status |
| 1 | done |
| 2 | init-done |
| 3 | CRC error |
| 4 | protocol-done |
| 5 | partial-reconfiguration ready |
| 6 | partial-reconfiguration error |
| 7 | partial-reconfiguration done |
| 8 | config pin |
| 9 | status pin |
| 10 | done pin |
| 11 | power-on |

A simple register port handles access. A write takes effect on the clock edge where the write strobe is sampled. Read data comes back, registered, one cycle after the read strobe together with a valid flag.

Top module: `cfgmon_irq_top`

## Requirements
- R1: The register addresses are fixed:
  - 0x830: enable
  - 0x834: mask
  - 0x838: trigger type
  - 0x83C: polarity
  - 0x840: masked status
  - 0x844: raw status
  - 0x84C: event clear, write-only, reads 0
  - 0x850: synchronized input levels

  The control registers read back bits 11:0 and read bits 31:12 as zero. Any other address reads 0. `bus_rvalid` and `bus_rdata` appear one cycle after `bus_rd`.
- R2: After reset, enable, mask, type and polarity are all zero, every pending bit is clear, and `irq` is low.
- R3: Each input passes through a two-stage synchronizer. The level read at 0x850 reflects an input change two clock edges after it. `irq` responds exactly four clock edges after an input change: two synchronizer stages, one pending stage and one output register.
- R4: A type bit of 0 selects level mode. The raw status bit then follows whether the input is active, where active means the input equals its polarity bit (1 = active high, 0 = active low).
- R5: A type bit of 1 selects edge mode. A transition of the input from inactive to active sets the raw status bit, and the bit stays set after the input goes inactive again.
- R6: Writing 1 to a bit of the clear register clears an edge-latched raw bit. Zero bits leave their raw bits unchanged. A new edge in the same cycle as the clear leaves the bit set. Clearing a level-mode bit has no effect.
- R7: Changing a polarity bit while the input is steady does not latch an edge event.
- R8: Each masked status bit equals raw AND enable AND NOT mask.
- R9: `irq` is the registered OR of all masked status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in | input | 12 | Asynchronous configuration status signals |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is an edge event that arrives on the same clock edge as a clear write for that bit. The pending stage sits behind the synchronizer, so the stimulus changes the input at a falling edge, waits two more falling edges, and then issues the clear write so that its sampling edge lands on the third rising edge. A polarity flip on a steady input is also exercised, in both directions, to show that it latches no event. Interrupt latency is checked cycle by cycle around the fourth edge.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;
  localparam int CFG_BITS = 12;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] A_ENABLE = 12'h830;
  localparam logic [ADDR_W-1:0] A_MASK   = 12'h834;
  localparam logic [ADDR_W-1:0] A_TYPE   = 12'h838;
  localparam logic [ADDR_W-1:0] A_POL    = 12'h83C;
  localparam logic [ADDR_W-1:0] A_MSTAT  = 12'h840;
  localparam logic [ADDR_W-1:0] A_RSTAT  = 12'h844;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 12'h84C;
  localparam logic [ADDR_W-1:0] A_LEVELS = 12'h850;

  typedef enum int {
    SIG_STATUS     = 0,
    SIG_DONE       = 1,
    SIG_INIT_DONE  = 2,
    SIG_CRC_ERR    = 3,
    SIG_PROTO_DONE = 4,
    SIG_PR_READY   = 5,
    SIG_PR_ERR     = 6,
    SIG_PR_DONE    = 7,
    SIG_CFG_PIN    = 8,
    SIG_STAT_PIN   = 9,
    SIG_DONE_PIN   = 10,
    SIG_POWER_ON   = 11
  } cfg_sig_e;
endpackage

// File: rtl/cfgmon_sync.sv
module cfgmon_sync #(
  parameter int NBITS  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] d,
  output logic [NBITS-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [NBITS-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/cfgmon_pending.sv
module cfgmon_pending #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] lvl,
  input  logic [NBITS-1:0] pol,
  input  logic [NBITS-1:0] trig_edge,
  input  logic [NBITS-1:0] clr,
  output logic [NBITS-1:0] raw
);
  logic [NBITS-1:0] prev_q;
  logic [NBITS-1:0] pend_q;
  logic [NBITS-1:0] act_now;
  logic [NBITS-1:0] act_prev;
  logic [NBITS-1:0] rise_act;

  // activity judged with the current polarity for both samples, so a
  // polarity change alone never creates a transition
  assign act_now  = ~(lvl ^ pol);
  assign act_prev = ~(prev_q ^ pol);
  assign rise_act = act_now & ~act_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      for (int i = 0; i < NBITS; i++) begin
        if (trig_edge[i]) pend_q[i] <= (pend_q[i] & ~clr[i]) | rise_act[i];
        else              pend_q[i] <= act_now[i];
      end
    end
  end

  assign raw = pend_q;

  // R5: an edge-latched bit with no clear stays set
  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
    |(trig_edge & pend_q & ~clr) |=> ((pend_q & $past(trig_edge & pend_q & ~clr))
                                     == $past(trig_edge & pend_q & ~clr)));

  // R6: a clear without a simultaneous new edge empties the bit
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    |(trig_edge & clr & ~rise_act) |=> ((pend_q & $past(trig_edge & clr & ~rise_act)) == '0));
endmodule

// File: rtl/cfgmon_regs.sv
module cfgmon_regs
  import cfgmon_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBITS-1:0]  wdata,
  input  logic [NBITS-1:0]  raw,
  input  logic [NBITS-1:0]  lvl,
  output logic [NBITS-1:0]  en,
  output logic [NBITS-1:0]  msk,
  output logic [NBITS-1:0]  trig_edge,
  output logic [NBITS-1:0]  pol,
  output logic [NBITS-1:0]  clr,
  output logic [NBITS-1:0]  masked,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int PAD = DATA_W - NBITS;

  logic [NBITS-1:0]  rd_sel;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= '0;
      msk       <= '0;
      trig_edge <= '0;
      pol       <= '0;
    end else if (wr) begin
      case (addr)
        A_ENABLE: en        <= wdata;
        A_MASK:   msk       <= wdata;
        A_TYPE:   trig_edge <= wdata;
        A_POL:    pol       <= wdata;
        default: ;
      endcase
    end
  end

  assign clr    = (wr && addr == A_CLEAR) ? wdata : '0;
  assign masked = raw & en & ~msk;

  always_comb begin
    case (addr)
      A_ENABLE: rd_sel = en;
      A_MASK:   rd_sel = msk;
      A_TYPE:   rd_sel = trig_edge;
      A_POL:    rd_sel = pol;
      A_MSTAT:  rd_sel = masked;
      A_RSTAT:  rd_sel = raw;
      A_LEVELS: rd_sel = lvl;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= {{PAD{1'b0}}, rd_sel};
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R1: the clear register always reads zero
  assert_clear_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_CLEAR) |=> (rvalid && rdata == '0));

  // R1: read data is valid exactly one cycle after a read strobe
  assert_read_valid_R1: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
endmodule

// File: rtl/cfgmon_irq_top.sv
module cfgmon_irq_top
  import cfgmon_pkg::*;
#(
  parameter int NBITS       = CFG_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBITS-1:0]  cfg_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NBITS-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic [NBITS-1:0] lvl;
  logic [NBITS-1:0] raw;
  logic [NBITS-1:0] en;
  logic [NBITS-1:0] msk;
  logic [NBITS-1:0] trig_edge;
  logic [NBITS-1:0] pol;
  logic [NBITS-1:0] clr;
  logic [NBITS-1:0] masked;
  logic             irq_q;

  cfgmon_sync #(.NBITS(NBITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cfg_in), .q(lvl)
  );

  cfgmon_pending #(.NBITS(NBITS)) u_pend (
    .clk(clk), .rst(rst), .lvl(lvl), .pol(pol), .trig_edge(trig_edge),
    .clr(clr), .raw(raw)
  );

  cfgmon_regs #(.NBITS(NBITS)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .raw(raw), .lvl(lvl), .en(en), .msk(msk),
    .trig_edge(trig_edge), .pol(pol), .clr(clr), .masked(masked),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end

  assign irq = irq_q;

  // R2: interrupt is low right after reset
  assert_reset_quiet_R2: assert property (@(posedge clk)
    $past(rst) |-> !irq);

  // R9: interrupt follows gated pending state one cycle later
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst || $past(rst))
    irq == |($past(raw) & $past(en) & ~$past(msk)));

  // R4: level-mode pending bits track the synchronized input activity
  assert_level_track_R4: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ((raw & ~$past(trig_edge)) == (~($past(lvl) ^ $past(pol)) & ~$past(trig_edge))));
endmodule

// File: tb/tb_cfgmon_irq_top.sv
module tb_cfgmon_irq_top;
  import cfgmon_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [11:0]       cfg_in = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [11:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic              irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  cfgmon_irq_top dut (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  // monitor: pops the expected read data when the design returns a read
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [11:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    settle(4);
    rst = 1'b0;
    settle(1);
    // R2: reset state
    chk_irq(1'b0, "R2");
    rd_expect(A_ENABLE, 32'h0, "R2");
    rd_expect(A_MASK,   32'h0, "R2");
    rd_expect(A_TYPE,   32'h0, "R2");
    rd_expect(A_POL,    32'h0, "R2");
    settle(3);
    // R4: inputs low, polarity 0 (active low), level mode -> all active
    rd_expect(A_RSTAT, 32'h0000_0FFF, "R4");

    // R1: upper bits read zero, clear reads 0, unknown address reads 0
    wr(A_POL, 12'hFFF);
    rd_expect(A_POL, 32'h0000_0FFF, "R1");
    rd_expect(A_CLEAR, 32'h0, "R1");
    rd_expect(12'h800, 32'h0, "R1");
    settle(2);
    rd_expect(A_RSTAT, 32'h0, "R4");

    // R3/R4: pattern on inputs, read levels and raw
    cfg_in = 12'hA5C;
    settle(4);
    rd_expect(A_LEVELS, 32'h0000_0A5C, "R3");
    rd_expect(A_RSTAT,  32'h0000_0A5C, "R4");
    cfg_in = 12'h000;
    settle(5);

    // R3: latency to irq is four rising edges
    wr(A_ENABLE, 12'h001);
    cfg_in = 12'h001;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk_irq(1'b0, "R3");
    @(negedge clk);
    chk_irq(1'b1, "R3");
    rd_expect(A_MSTAT, 32'h0000_0001, "R8");

    // R8: mask and enable gating
    wr(A_MASK, 12'h001);
    settle(1);
    chk_irq(1'b0, "R9");
    rd_expect(A_MSTAT, 32'h0, "R8");
    rd_expect(A_RSTAT, 32'h0000_0001, "R8");
    wr(A_MASK, 12'h000);
    settle(1);
    chk_irq(1'b1, "R9");
    wr(A_ENABLE, 12'h000);
    settle(1);
    chk_irq(1'b0, "R8");

    // R6: clearing a level bit has no effect
    wr(A_CLEAR, 12'h001);
    rd_expect(A_RSTAT, 32'h0000_0001, "R6");
    // R4: level follows input back down
    cfg_in = 12'h000;
    settle(4);
    rd_expect(A_RSTAT, 32'h0, "R4");

    // R5: rising edge on bit1 latches
    wr(A_TYPE, 12'h002);
    wr(A_ENABLE, 12'h002);
    cfg_in = 12'h002;
    settle(5);
    chk_irq(1'b1, "R5");
    cfg_in = 12'h000;
    settle(5);
    rd_expect(A_RSTAT, 32'h0000_0002, "R5");
    chk_irq(1'b1, "R5");
    wr(A_CLEAR, 12'h001);
    settle(1);
    rd_expect(A_RSTAT, 32'h0000_0002, "R6");
    wr(A_CLEAR, 12'h002);
    settle(1);
    rd_expect(A_RSTAT, 32'h0, "R6");
    chk_irq(1'b0, "R9");

    // R6: edge and clear on the same edge -> bit stays set
    cfg_in = 12'h002;
    @(negedge clk);
    @(negedge clk);
    wr(A_CLEAR, 12'h002);
    settle(1);
    rd_expect(A_RSTAT, 32'h0000_0002, "R6");
    wr(A_CLEAR, 12'h002);
    cfg_in = 12'h000;
    settle(4);

    // R7: bit2 falls to active-low polarity with input low, no event
    wr(A_TYPE, 12'h006);
    wr(A_POL, 12'hFFB);
    settle(3);
    rd_expect(A_RSTAT, 32'h0, "R7");
    // R5: falling edge latches with active-low polarity
    cfg_in = 12'h004;
    settle(4);
    cfg_in = 12'h000;
    settle(4);
    rd_expect(A_RSTAT, 32'h0000_0004, "R5");
    wr(A_CLEAR, 12'h004);
    settle(1);
    rd_expect(A_RSTAT, 32'h0, "R6");

    // R7: bit3 high and inactive, then polarity flips to active high
    wr(A_TYPE, 12'h00E);
    wr(A_POL, 12'hFF3);
    cfg_in = 12'h008;
    settle(4);
    rd_expect(A_RSTAT, 32'h0, "R7");
    wr(A_POL, 12'hFFB);
    settle(3);
    rd_expect(A_RSTAT, 32'h0, "R7");

    settle(4);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule